// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Pair

This block multiplies or divides two 32-bit integers in either signed or unsigned form. It writes every result into a dedicated pair of 32-bit result registers, HI and LO, which sit outside any general register file. A product of 64 bits is split across the pair, with its upper word in HI and its lower word in LO. A division leaves the quotient in LO and the remainder in HI, so that dividend equals quotient times divisor plus remainder. No operation ever reports overflow. Software that needs to know whether a product overflowed inspects HI itself.

A request carries an opcode and two operands on a valid/ready handshake. The unit takes a request at a clock edge where `req_valid` and `req_ready` are both high. It then stays busy for one setup cycle and 32 iteration cycles, and `req_ready` stays low for that whole time. No queue holds back-pressured requests. A request that is presented while `req_ready` is low is not taken, and the sender must keep it valid until ready returns if it wants it executed. The `hi_out` and `lo_out` read ports serve move-from-HI and move-from-LO instructions. They always show the most recent completed result, and `done` pulses for one cycle when that result is written.

Top module: `muldiv_unit`

## Requirements
- R1: Opcode 2'b01 (unsigned multiply) writes the 64-bit unsigned product of `req_a` and `req_b`, with bits 63..32 in HI and bits 31..0 in LO.
- R2: Opcode 2'b00 (signed multiply) treats both operands as two's complement and writes the 64-bit two's complement product split the same way, upper word in HI and lower word in LO.
- R3: Opcode 2'b11 (unsigned divide) with a nonzero divisor writes `req_a / req_b` into LO and `req_a % req_b` into HI.
- R4: Opcode 2'b10 (signed divide) with a nonzero divisor truncates the quotient toward zero and gives the remainder the sign of the dividend. Dividing 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0. No flag is raised for this or any other case.
- R5: Either divide opcode with a divisor of zero completes normally, writing LO = 0xFFFFFFFF and HI = the dividend unchanged.
- R6: After reset `req_ready` is high while the unit is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `busy` is then high for exactly 33 consecutive cycles, and `req_ready` is low for that whole time.
- R7: `done` is high for exactly one cycle, the cycle right after `busy` falls. `hi_out` and `lo_out` change only in the cycle where `done` is high.
- R8: A request presented while `req_ready` is low is dropped. It produces no `done` and does not alter the result of the operation already in flight.
- R9: While reset is asserted and right after it, HI = 0, LO = 0, `busy` = 0, `done` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The unit is idle and will take a request at this edge |
| req_op | input | 2 | 00 signed multiply, 01 unsigned multiply, 10 signed divide, 11 unsigned divide |
| req_a | input | 32 | Multiplicand or dividend |
| req_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | The unit is iterating on a taken request |
| done | output | 1 | One-cycle pulse when HI and LO have just been written |
| hi_out | output | 32 | Move-from-HI read port |
| lo_out | output | 32 | Move-from-LO read port |

## Verification
The bench goes after signed division where the signs of the operands differ. A unit that floors the quotient, or that takes the remainder's sign from the divisor, returns -4 instead of -3 for -7/2 and leaves a remainder of the wrong sign. It drives the most negative value through both the signed multiply and the signed divide by -1. A design that computes operand magnitudes in only 31 bits, or that saturates the result, gets the wrong HI word or the wrong quotient there. It also checks division by zero in both signed and unsigned form, because sign fix-up applied to the all-ones quotient would corrupt both LO and HI. Finally it presents requests while the unit is busy: a design that takes them would shorten the busy window, raise an extra `done`, or overwrite the result of the operation in flight.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2
  } md_state_e;
endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep #(
  parameter int W = 32
) (
  input  logic         signed_op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_a,
  output logic         neg_b
);
  // Magnitudes fit in W unsigned bits, including the most negative value.
  always_comb begin
    neg_a = signed_op & a_in[W-1];
    neg_b = signed_op & b_in[W-1];
    mag_a = neg_a ? (~a_in + 1'b1) : a_in;
    mag_b = neg_b ? (~b_in + 1'b1) : b_in;
  end
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod_next
);
  logic [W-1:0] acc_hi_q, acc_lo_q, mcand_q;
  logic [W:0]   sum;
  logic [W-1:0] nxt_hi, nxt_lo;

  // One shift-add step: add the multiplicand when the low bit is set, then shift right.
  always_comb begin
    sum    = {1'b0, acc_hi_q} + (acc_lo_q[0] ? {1'b0, mcand_q} : '0);
    nxt_hi = sum[W:1];
    nxt_lo = {sum[0], acc_lo_q[W-1:1]};
  end

  assign prod_next = {nxt_hi, nxt_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      mcand_q  <= '0;
    end else if (load) begin
      acc_hi_q <= '0;
      acc_lo_q <= mplier_in;
      mcand_q  <= mcand_in;
    end else if (step) begin
      acc_hi_q <= nxt_hi;
      acc_lo_q <= nxt_lo;
    end
  end
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_in,
  input  logic [W-1:0] dsr_in,
  output logic [W-1:0] quo_next,
  output logic [W-1:0] rem_next
);
  logic [W-1:0] rem_q, quo_q, dsr_q;
  logic [W:0]   shifted, trial;
  logic         fits;

  // One restoring step: shift in the next dividend bit and try a subtraction.
  always_comb begin
    shifted  = {rem_q, quo_q[W-1]};
    trial    = shifted - {1'b0, dsr_q};
    fits     = ~trial[W];
    rem_next = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_next = {quo_q[W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_in;
      dsr_q <= dsr_in;
    end else if (step) begin
      rem_q <= rem_next;
      quo_q <= quo_next;
    end
  end
endmodule

// File: rtl/md_result_fix.sv
module md_result_fix
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  md_op_e         op,
  input  logic [2*W-1:0] prod,
  input  logic [W-1:0]   quo,
  input  logic [W-1:0]   rem,
  input  logic           neg_a,
  input  logic           neg_b,
  input  logic           dsr_zero,
  input  logic [W-1:0]   dividend,
  output logic [W-1:0]   hi,
  output logic [W-1:0]   lo
);
  logic [2*W-1:0] prod_s;
  logic [W-1:0]   quo_s, rem_s;

  always_comb begin
    prod_s = (neg_a ^ neg_b) ? (~prod + 1'b1) : prod;
    quo_s  = (neg_a ^ neg_b) ? (~quo + 1'b1) : quo;
    rem_s  = neg_a ? (~rem + 1'b1) : rem;
    if (op == OP_MUL_S || op == OP_MUL_U) begin
      hi = prod_s[2*W-1:W];
      lo = prod_s[W-1:0];
    end else if (dsr_zero) begin
      hi = dividend;
      lo = '1;
    end else begin
      hi = rem_s;
      lo = quo_s;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [WIDTH-1:0] req_a,
  input  logic [WIDTH-1:0] req_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi_out,
  output logic [WIDTH-1:0] lo_out
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  md_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  md_op_e           op_q;
  logic [WIDTH-1:0] a_q, b_q, hi_q, lo_q;
  logic             done_q;

  logic             is_signed, load, step, last;
  logic [WIDTH-1:0] mag_a, mag_b, quo_n, rem_n, fix_hi, fix_lo;
  logic             neg_a, neg_b;
  logic [2*WIDTH-1:0] prod_n;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign hi_out    = hi_q;
  assign lo_out    = lo_q;

  assign is_signed = (op_q == OP_MUL_S) || (op_q == OP_DIV_S);
  assign load      = (state_q == ST_SETUP);
  assign step      = (state_q == ST_ITER);
  assign last      = step && (cnt_q == LAST_STEP);

  md_operand_prep #(.W(WIDTH)) u_prep (
    .signed_op (is_signed),
    .a_in      (a_q),
    .b_in      (b_q),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_a     (neg_a),
    .neg_b     (neg_b)
  );

  md_mul_core #(.W(WIDTH)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (mag_a),
    .mplier_in (mag_b),
    .prod_next (prod_n)
  );

  md_div_core #(.W(WIDTH)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .dvd_in   (mag_a),
    .dsr_in   (mag_b),
    .quo_next (quo_n),
    .rem_next (rem_n)
  );

  md_result_fix #(.W(WIDTH)) u_fix (
    .op       (op_q),
    .prod     (prod_n),
    .quo      (quo_n),
    .rem      (rem_n),
    .neg_a    (neg_a),
    .neg_b    (neg_b),
    .dsr_zero (b_q == '0),
    .dividend (a_q),
    .hi       (fix_hi),
    .lo       (fix_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_MUL_S;
      a_q     <= '0;
      b_q     <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= md_op_e'(req_op);
            a_q     <= req_a;
            b_q     <= req_b;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt_q   <= '0;
          state_q <= ST_ITER;
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            hi_q    <= fix_hi;
            lo_q    <= fix_lo;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/md_checker.sv
module md_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi_out,
  input logic [WIDTH-1:0] lo_out
);
  localparam int BUSY_LEN = WIDTH + 1;
  localparam int BW = $clog2(BUSY_LEN + 2) + 1;

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + 1'b1;
  end

  // R6: a taken request makes the unit busy in the next cycle
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  // R6: the busy window is setup plus one cycle per bit
  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == BW'(BUSY_LEN)));

  // R7: the result registers move only with done
  a_r7_hilo_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hi_out) || !$stable(lo_out)) |-> done);

  // R7: done follows the fall of busy
  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R7: a fall of busy always gives done
  a_r7_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind muldiv_unit md_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_a = '0, req_b = '0;
  logic        busy, done;
  logic [31:0] hi_out, lo_out;

  int checks = 0;
  int fails = 0;
  int busy_len = 0;
  int dones = 0;
  int pushed = 0;
  int stray = 0;
  bit finished = 0;
  logic [31:0] prev_hi = '0, prev_lo = '0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy), .done(done),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  function automatic logic [63:0] model(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin p = 64'(sa * sb); return p; end
      2'b01: begin p = {32'b0, a} * {32'b0, b}; return p; end
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(string tag, logic [1:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    exp_q.push_back(model(op, a, b));
    tag_q.push_back(tag);
    pushed++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!done && (hi_out !== prev_hi || lo_out !== prev_lo)) stray++;
      if (busy) busy_len++;
      if (done) begin
        dones++;
        check("R6 busy length", 64'(busy_len), 64'd33);
        busy_len = 0;
        if (exp_q.size() == 0) begin
          check("R8 spurious done", 64'd1, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {hi_out, lo_out}, e);
        end
      end
      prev_hi = hi_out;
      prev_lo = lo_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 hi/lo in reset", {hi_out, lo_out}, 64'd0);
    check("R9 flags in reset", {61'd0, busy, done, req_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 hi/lo after reset", {hi_out, lo_out}, 64'd0);
    check("R9 R6 flags after reset", {61'd0, busy, done, req_ready}, 64'd1);

    do_op("R1 3*5",              2'b01, 32'd3, 32'd5);
    do_op("R1 max*max",          2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_op("R1 x*0",              2'b01, 32'h1234_5678, 32'd0);
    do_op("R2 -1*-1",            2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_op("R2 -3*7",             2'b00, 32'hFFFF_FFFD, 32'd7);
    do_op("R2 min*min",          2'b00, 32'h8000_0000, 32'h8000_0000);
    do_op("R2 min*1",            2'b00, 32'h8000_0000, 32'd1);
    do_op("R3 100/7",            2'b11, 32'd100, 32'd7);
    do_op("R3 max/1",            2'b11, 32'hFFFF_FFFF, 32'd1);
    do_op("R3 5/10",             2'b11, 32'd5, 32'd10);
    do_op("R3 big/big",          2'b11, 32'hF000_0001, 32'h8000_0000);
    do_op("R4 -7/2",             2'b10, 32'hFFFF_FFF9, 32'd2);
    do_op("R4 7/-2",             2'b10, 32'd7, 32'hFFFF_FFFE);
    do_op("R4 -7/-2",            2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    do_op("R4 min/-1",           2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    do_op("R5 unsigned /0",      2'b11, 32'hDEAD_BEEF, 32'd0);
    do_op("R5 signed neg /0",    2'b10, 32'hFFFF_FFF9, 32'd0);
    do_op("R5 signed pos /0",    2'b10, 32'd42, 32'd0);

    // R8: requests while busy must be dropped
    do_op("R8 in-flight 1000/3", 2'b11, 32'd1000, 32'd3);
    for (int i = 0; i < 5; i++) begin
      req_valid = 1'b1; req_op = 2'b01; req_a = 32'hAAAA_0000 + i; req_b = 32'd9;
      @(negedge clk);
    end
    req_valid = 1'b0;
    do_op("R8 after drop 6*7",   2'b00, 32'd6, 32'd7);

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R8 done count", 64'(dones), 64'(pushed));
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);
    check("R7 hi/lo moved only with done", 64'(stray), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule